// File: doc/BRIEF.md
# Bytecode Stack Machine Executor

This block is a small multi-cycle executor for a byte-coded, 32-bit stack instruction set. The word on top of the stack is kept in a cached register (TOS), so most instructions need only one data-memory access. The register file is a stack pointer (SP), a program counter (PC) and a local-frame base (LV). Code lives in an internal byte-addressed memory and the stack and local variables live in an internal word-addressed memory. A hardwired state machine walks the program. Almost every instruction takes one cycle. Instructions that remove the top word take one more cycle to refill TOS from memory.

The host loads a program through a byte write port while the block is idle, then pulses `start`. On that pulse the block writes the current TOS (zero after reset) to the stack slot at SP, which makes TOS and memory agree. Execution starts at code address 0 and continues until a halt opcode or an illegal opcode. The host sees the result on `tos` and `sp`, and `halted` and `err` report how the run ended. LV is fixed at the parameter `LV_BASE`. SP starts at `SP_BASE`. Data addresses wrap modulo the data-memory depth.

Top module: `stack_exec`

## Requirements
- R1: After reset `halted`=0, `err`=0, `tos`=0 and `sp`=SP_BASE (0x080 by default). Nothing executes until `start` is pulsed, and code bytes are written only while idle.
- R2: Opcode values are BIPUSH=0x10, ILOAD=0x15, ISTORE=0x36, POP=0x57, DUP=0x59, IADD=0x60, IINC=0x84, IFEQ=0x99, IFLT=0x9B, IF_ICMPEQ=0x9F, GOTO=0xA7, WIDE=0xC4 and HALT=0xFF. HALT sets `halted`=1 with `err`=0.
- R3: BIPUSH pushes its following byte, sign-extended to 32 bits. `sp` rises by one and `tos` shows the value.
- R4: IADD replaces the top two words with their 32-bit sum, which appears on `tos`, and `sp` falls by one.
- R5: POP drops the top word and `tos` then shows the word that was below it. DUP pushes a copy of `tos`.
- R6: ILOAD pushes the local word at LV plus its one-byte index, read as unsigned. ISTORE pops `tos` into that local word. After ISTORE, `tos` holds the new top word, even when the store target is that very slot.
- R7: WIDE placed before ILOAD or ISTORE makes the index 16 bits. The two index bytes follow the opcode, high byte first.
- R8: IINC (index byte, then a signed constant byte) adds the constant to the local word. When that word is the top of stack, `tos` shows the updated value.
- R9: GOTO adds its signed 16-bit offset (high byte first) to the address of the GOTO opcode itself. Negative offsets branch backward.
- R10: IFLT and IFEQ pop one word and branch by their offset (taken from the opcode's address) when that word is negative or zero respectively. Otherwise they continue after their three bytes.
- R11: IF_ICMPEQ pops two words and branches only when they are equal. `tos` then shows the word below the popped pair.
- R12: An unknown opcode, or WIDE followed by anything other than ILOAD or ISTORE, sets `err`=1 and `halted`=1.
- R13: Once halted, the block ignores `start`, and `tos`, `sp`, `halted` and `err` hold until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Code byte write enable (accepted only while idle) |
| ld_addr | input | CODE_AW (8) | Code byte address |
| ld_byte | input | 8 | Code byte value |
| start | input | 1 | Pulse to begin execution at code address 0 |
| halted | output | 1 | Execution stopped |
| err | output | 1 | Stopped on an illegal opcode |
| tos | output | DW (32) | Cached top-of-stack word |
| sp | output | DATA_AW (10) | Stack pointer (word address of the top word) |

## Verification
The hardest case to reach from the ports is a write that lands on the stack slot TOS mirrors. This happens when ISTORE stores into the word just below the top, or when IINC modifies the current top word. Both need a program that aims a local-variable index at a stack address. The stimulus sets that up by choosing the index as SP minus LV, so the refill path must pick up the freshly written value. The WIDE byte order is separated from the plain index by storing through a wide index and loading back through a narrow one. Branch arithmetic is exercised by a counted loop whose backward GOTO and exit IFEQ both depend on the opcode-relative offset.

// File: rtl/stack_exec_pkg.sv
// Shared opcode values and controller state encoding for the stack executor.
package stack_exec_pkg;
    localparam logic [7:0] OP_BIPUSH  = 8'h10;
    localparam logic [7:0] OP_ILOAD   = 8'h15;
    localparam logic [7:0] OP_ISTORE  = 8'h36;
    localparam logic [7:0] OP_POP     = 8'h57;
    localparam logic [7:0] OP_DUP     = 8'h59;
    localparam logic [7:0] OP_IADD    = 8'h60;
    localparam logic [7:0] OP_IINC    = 8'h84;
    localparam logic [7:0] OP_IFEQ    = 8'h99;
    localparam logic [7:0] OP_IFLT    = 8'h9B;
    localparam logic [7:0] OP_IFCMPEQ = 8'h9F;
    localparam logic [7:0] OP_GOTO    = 8'hA7;
    localparam logic [7:0] OP_WIDE    = 8'hC4;
    localparam logic [7:0] OP_HALT    = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_REFILL = 2'd2,
        ST_STOP   = 2'd3
    } state_t;
endpackage

// File: rtl/stack_exec_code.sv
// Byte-wide code store. Writes are synchronous; reads present a window of
// WIN consecutive bytes starting at raddr (wrapping), combinationally.
// Assumes the writer only writes while the reader is not executing.
module stack_exec_code #(
    parameter int AW  = 8,
    parameter int WIN = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [7:0]        wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WIN*8-1:0]  window
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Store one code byte per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Byte k of the window is the code byte at raddr + k.
    for (genvar k = 0; k < WIN; k++) begin : g_win
        assign window[k*8 +: 8] = mem[raddr + AW'(k)];
    end
endmodule

// File: rtl/stack_exec_data.sv
// Word-addressed data store for stack and locals: one asynchronous read
// port and one synchronous write port. A read of a slot being written in
// the same cycle returns the old contents.
module stack_exec_data #(
    parameter int DW = 32,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Commit one word per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/stack_exec_nextpc.sv
// Next program counter: either the opcode address plus a signed 16-bit
// offset (taken branch) or the opcode address plus the instruction length.
// Assumes AW is at most 16, so the offset is truncated to the code space.
module stack_exec_nextpc #(
    parameter int AW = 8
) (
    input  logic [AW-1:0] pc,
    input  logic [15:0]   offset,
    input  logic          take,
    input  logic [2:0]    len,
    output logic [AW-1:0] next_pc
);
    // Select between relative jump and sequential advance.
    always_comb begin
        if (take) next_pc = pc + AW'(offset);
        else      next_pc = pc + AW'(len);
    end
endmodule

// File: rtl/stack_exec.sv
// Multi-cycle bytecode stack executor. TOS caches the word at data[SP];
// every instruction leaves that invariant true. Instructions that shrink
// the stack or may overwrite the top slot take an extra refill cycle that
// reloads TOS from data[SP]. Assumes CODE_AW <= 16 and programs that do not
// underflow the stack.
module stack_exec #(
    parameter int DW      = 32,
    parameter int CODE_AW = 8,
    parameter int DATA_AW = 10,
    parameter int SP_BASE = 'h080,
    parameter int LV_BASE = 'h010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_we,
    input  logic [CODE_AW-1:0] ld_addr,
    input  logic [7:0]         ld_byte,
    input  logic               start,
    output logic               halted,
    output logic               err,
    output logic [DW-1:0]      tos,
    output logic [DATA_AW-1:0] sp
);
    import stack_exec_pkg::*;

    localparam int WIN = 4;
    localparam logic [DATA_AW-1:0] SP_RST = DATA_AW'(SP_BASE);
    localparam logic [DATA_AW-1:0] LV_REG = DATA_AW'(LV_BASE);

    state_t             state_q, state_d;
    logic [CODE_AW-1:0] pc_q, pc_d;
    logic [DATA_AW-1:0] sp_q, sp_d;
    logic [DW-1:0]      tos_q, tos_d;
    logic               err_q, err_d;

    logic [WIN*8-1:0]   window;
    logic [7:0]         b0, b1, b2, b3, op;
    logic               wide;
    logic [15:0]        index;
    logic [DATA_AW-1:0] lv_addr, sp_up, sp_dn;
    logic [DW-1:0]      rdata, wdata, imm8, inc8;
    logic [DATA_AW-1:0] raddr, waddr;
    logic               we, take;
    logic [2:0]         len;
    logic [CODE_AW-1:0] next_pc;

    stack_exec_code #(.AW(CODE_AW), .WIN(WIN)) i_code (
        .clk(clk), .we(ld_we && state_q == ST_IDLE), .waddr(ld_addr),
        .wdata(ld_byte), .raddr(pc_q), .window(window)
    );

    stack_exec_data #(.DW(DW), .AW(DATA_AW)) i_data (
        .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );

    stack_exec_nextpc #(.AW(CODE_AW)) i_npc (
        .pc(pc_q), .offset({b1, b2}), .take(take), .len(len), .next_pc(next_pc)
    );

    assign b0      = window[7:0];
    assign b1      = window[15:8];
    assign b2      = window[23:16];
    assign b3      = window[31:24];
    assign wide    = (b0 == OP_WIDE);
    assign op      = wide ? b1 : b0;
    assign index   = wide ? {b2, b3} : {8'h00, b1};
    assign lv_addr = LV_REG + DATA_AW'(index);
    assign sp_up   = sp_q + DATA_AW'(1);
    assign sp_dn   = sp_q - DATA_AW'(1);
    assign imm8    = {{(DW-8){b1[7]}}, b1};
    assign inc8    = {{(DW-8){b2[7]}}, b2};

    // Decode the current state and opcode into next-state and memory controls.
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        sp_d    = sp_q;
        tos_d   = tos_q;
        err_d   = err_q;
        raddr   = sp_q;
        waddr   = sp_q;
        wdata   = tos_q;
        we      = 1'b0;
        take    = 1'b0;
        len     = 3'd1;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    we      = 1'b1;
                    state_d = ST_EXEC;
                end
            end
            ST_EXEC: begin
                pc_d = next_pc;
                if (wide && op != OP_ILOAD && op != OP_ISTORE) begin
                    err_d   = 1'b1;
                    state_d = ST_STOP;
                end else begin
                    case (op)
                        OP_HALT: state_d = ST_STOP;
                        OP_BIPUSH: begin
                            len = 3'd2; we = 1'b1; waddr = sp_up; wdata = imm8;
                            sp_d = sp_up; tos_d = imm8;
                        end
                        OP_DUP: begin
                            we = 1'b1; waddr = sp_up; sp_d = sp_up;
                        end
                        OP_IADD: begin
                            raddr = sp_dn; we = 1'b1; waddr = sp_dn;
                            wdata = rdata + tos_q; sp_d = sp_dn; tos_d = rdata + tos_q;
                        end
                        OP_POP: begin
                            sp_d = sp_dn; state_d = ST_REFILL;
                        end
                        OP_ILOAD: begin
                            len = wide ? 3'd4 : 3'd2; raddr = lv_addr;
                            we = 1'b1; waddr = sp_up; wdata = rdata;
                            sp_d = sp_up; tos_d = rdata;
                        end
                        OP_ISTORE: begin
                            len = wide ? 3'd4 : 3'd2; we = 1'b1; waddr = lv_addr;
                            sp_d = sp_dn; state_d = ST_REFILL;
                        end
                        OP_IINC: begin
                            len = 3'd3; raddr = lv_addr; we = 1'b1; waddr = lv_addr;
                            wdata = rdata + inc8; state_d = ST_REFILL;
                        end
                        OP_GOTO: take = 1'b1;
                        OP_IFLT, OP_IFEQ: begin
                            len  = 3'd3;
                            take = (op == OP_IFLT) ? tos_q[DW-1] : (tos_q == '0);
                            sp_d = sp_dn; state_d = ST_REFILL;
                        end
                        OP_IFCMPEQ: begin
                            len = 3'd3; raddr = sp_dn; take = (rdata == tos_q);
                            sp_d = sp_q - DATA_AW'(2); state_d = ST_REFILL;
                        end
                        default: begin
                            err_d = 1'b1; state_d = ST_STOP;
                        end
                    endcase
                end
            end
            ST_REFILL: begin
                raddr   = sp_q;
                tos_d   = rdata;
                state_d = ST_EXEC;
            end
            default: ;
        endcase
    end

    // Register the architectural state with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            sp_q    <= SP_RST;
            tos_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            sp_q    <= sp_d;
            tos_q   <= tos_d;
            err_q   <= err_d;
        end
    end

    assign halted = (state_q == ST_STOP);
    assign err    = err_q;
    assign tos    = tos_q;
    assign sp     = sp_q;
endmodule

// File: rtl/stack_exec_chk.sv
// Temporal checks on the executor's outputs, attached by bind.
module stack_exec_chk #(
    parameter int DW = 32,
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halted,
    input logic          err,
    input logic [DW-1:0] tos,
    input logic [AW-1:0] sp
);
    // R12
    err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> halted);

    // R12
    err_with_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $rose(halted));

    // R13
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(tos) && $stable(sp) && $stable(err));

    // R4
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp == $past(sp)) || (sp == $past(sp) + AW'(1)) ||
        (sp == $past(sp) - AW'(1)) || (sp == $past(sp) - AW'(2)));
endmodule

bind stack_exec stack_exec_chk #(.DW(DW), .AW(DATA_AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .halted(halted), .err(err), .tos(tos), .sp(sp)
);

// File: tb/test_stack_exec.sv
// Scoreboard bench: the driver loads a program and queues the expected final
// state; the monitor compares it when the executor halts.
module test_stack_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [7:0]  ld_byte = '0;
    logic        start = 1'b0;
    logic        halted, err;
    logic [31:0] tos;
    logic [9:0]  sp;

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] tos;
        logic [9:0]  sp;
        logic        err;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] prog[$];
    int         checks = 0;
    int         errors = 0;
    int         done   = 0;

    stack_exec i_stack_exec (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_byte(ld_byte), .start(start), .halted(halted), .err(err),
        .tos(tos), .sp(sp)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load();
        foreach (prog[i]) begin
            @(negedge clk);
            ld_we = 1'b1; ld_addr = 8'(i); ld_byte = prog[i];
        end
        @(negedge clk); ld_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Driver: reset, load, queue expectation, start, wait for monitor.
    task automatic run(input logic [23:0] tag, input logic [31:0] t,
                       input logic [9:0] s, input logic e);
        int target;
        do_reset();
        load();
        sb.push_back('{tag: tag, tos: t, sp: s, err: e});
        target = done + 1;
        pulse_start();
        wait (done == target);
    endtask

    // Monitor: on each halt, pop the expected state and compare.
    initial begin
        forever begin
            exp_t x;
            @(posedge halted);
            @(negedge clk);
            x = sb.pop_front();
            check(x.tag, tos, x.tos);
            check(x.tag, {22'd0, sp}, {22'd0, x.sp});
            check(x.tag, {31'd0, err}, {31'd0, x.err});
            done++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state and idle before start
        prog = '{8'hFF};
        do_reset();
        load();
        repeat (5) @(negedge clk);
        check("R1", {31'd0, halted}, 32'd0);
        check("R1", tos, 32'd0);
        check("R1", {22'd0, sp}, 32'h080);
        check("R1", {31'd0, err}, 32'd0);

        // R2: plain halt
        prog = '{8'hFF};
        run("R2", 32'h0, 10'h080, 1'b0);
        // R13: start while halted is ignored, state holds
        pulse_start();
        repeat (5) @(negedge clk);
        check("R13", {31'd0, halted}, 32'd1);
        check("R13", tos, 32'h0);
        check("R13", {22'd0, sp}, 32'h080);

        // R3: negative and positive immediates
        prog = '{8'h10, 8'h80, 8'hFF};
        run("R3", 32'hFFFF_FF80, 10'h081, 1'b0);
        // R4: add
        prog = '{8'h10, 8'h7F, 8'h10, 8'h05, 8'h60, 8'hFF};
        run("R4", 32'h84, 10'h081, 1'b0);
        // R5: pop refills, then dup and add
        prog = '{8'h10, 8'h07, 8'h10, 8'h09, 8'h57, 8'hFF};
        run("R5", 32'h7, 10'h081, 1'b0);
        prog = '{8'h10, 8'h07, 8'h10, 8'h09, 8'h57, 8'h59, 8'h60, 8'hFF};
        run("R5", 32'hE, 10'h081, 1'b0);
        // R6: store and load through an index above 0x7F
        prog = '{8'h10, 8'h2A, 8'h36, 8'hC8, 8'h10, 8'hFF, 8'h15, 8'hC8, 8'h60, 8'hFF};
        run("R6", 32'h29, 10'h081, 1'b0);
        // R6: store onto the slot just below the top refills tos
        prog = '{8'h10, 8'h05, 8'h10, 8'h09, 8'h36, 8'h71, 8'hFF};
        run("R6", 32'h9, 10'h081, 1'b0);
        // R7: wide index high byte first, mixed with narrow load
        prog = '{8'h10, 8'h11, 8'hC4, 8'h36, 8'h01, 8'h02, 8'h10, 8'h22,
                 8'hC4, 8'h36, 8'h00, 8'hC8, 8'h15, 8'hC8, 8'hC4, 8'h15,
                 8'h01, 8'h02, 8'h60, 8'hFF};
        run("R7", 32'h33, 10'h081, 1'b0);
        // R8: increment the top-of-stack slot by -3
        prog = '{8'h10, 8'h0A, 8'h84, 8'h71, 8'hFD, 8'h10, 8'h01, 8'h60, 8'hFF};
        run("R8", 32'h8, 10'h081, 1'b0);
        // R9: forward jump
        prog = '{8'hA7, 8'h00, 8'h05, 8'h10, 8'h01, 8'h10, 8'h02, 8'hFF};
        run("R9", 32'h2, 10'h081, 1'b0);
        // R9 R10 R8 R6 R4: counted loop summing 3+2+1
        prog = '{8'h10, 8'h03, 8'h36, 8'h00, 8'h10, 8'h00, 8'h15, 8'h00,
                 8'h99, 8'h00, 8'h0C, 8'h15, 8'h00, 8'h60, 8'h84, 8'h00,
                 8'hFF, 8'hA7, 8'hFF, 8'hF5, 8'hFF};
        run("R9", 32'h6, 10'h081, 1'b0);
        // R10: less-than taken and not taken
        prog = '{8'h10, 8'hFB, 8'h9B, 8'h00, 8'h06, 8'h10, 8'h01, 8'hFF, 8'h10, 8'h02, 8'hFF};
        run("R10", 32'h2, 10'h081, 1'b0);
        prog = '{8'h10, 8'h05, 8'h9B, 8'h00, 8'h06, 8'h10, 8'h01, 8'hFF, 8'h10, 8'h02, 8'hFF};
        run("R10", 32'h1, 10'h081, 1'b0);
        // R11: equal pair branches and refills, unequal falls through
        prog = '{8'h10, 8'h07, 8'h10, 8'h04, 8'h10, 8'h04, 8'h9F, 8'h00, 8'h05,
                 8'h10, 8'h01, 8'hFF};
        run("R11", 32'h7, 10'h081, 1'b0);
        prog = '{8'h10, 8'h07, 8'h10, 8'h04, 8'h10, 8'h05, 8'h9F, 8'h00, 8'h05,
                 8'h10, 8'h01, 8'hFF};
        run("R11", 32'h1, 10'h082, 1'b0);
        // R12: unknown opcode and bad wide pairing
        prog = '{8'h10, 8'h03, 8'h01};
        run("R12", 32'h3, 10'h081, 1'b1);
        prog = '{8'hC4, 8'h59, 8'hFF};
        run("R12", 32'h0, 10'h080, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule